// File: doc/BRIEF.md
# In-Place Exchange Sorter

This block holds a small file of unsigned words and rearranges them into ascending order by address. A host first fills the file one word at a time, selecting the word by address, and may read any word back. It then raises a start request, and the block runs a two-index compare-and-exchange pass over its own storage without further help from the host. When the pass ends, a completion flag is raised and held until the host withdraws the start request.

The outer index walks every position except the last. It keeps a running candidate taken from that position. The inner index walks every later position. Whenever the word under the inner index is smaller than the candidate, the two words trade places, one write per clock cycle, and the candidate is reloaded from the outer position. Storage size is a power of two set by the address width. A mode input separates host loading and reading from sorting.

Top module: `reg_exchange_sorter`

## Requirements
- R1: After reset, done_o is 0, data_o is 0 and every storage word reads back as 0.
- R2: With mode_i=0 and no sort running, wr_en_i high at a rising edge stores data_i at address addr_i.
- R3: With mode_i=0 and no sort running, rd_en_i high at a rising edge loads the word at addr_i into data_o, visible after that edge. data_o holds its value in every cycle without such a read.
- R4: A sort starts only when start_i and mode_i are both 1 while the block waits. start_i with mode_i=0 does nothing, and done_o never rises.
- R5: At the end of a sort the words are in ascending unsigned order from address 0 upward. For example, 8'h80 sorts after 8'h7F.
- R6: Counted in rising edges after the start edge, done_o rises after exactly one edge per outer position, plus two per comparison, plus three per exchange. An exchange happens only when the later word is strictly smaller than the candidate, so equal words are never exchanged.
- R7: done_o stays 1 while start_i stays 1. At the first edge with start_i=0 it falls to 0 and the block waits again, so a new sort can be started.
- R8: While a sort runs, wr_en_i and rd_en_i are ignored: no word changes and data_o holds.
- R9: With four words 3,2,4,1 at addresses 0 to 3, the sort ends as 1,2,3,4 after six comparisons and four exchanges, which is 27 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = host load/read, 1 = sort |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | ADDR_W | Host word address |
| data_i | input | DATA_W | Host write data |
| start_i | input | 1 | Sort request, held until done_o is seen |
| data_o | output | DATA_W | Registered read data |
| done_o | output | 1 | Sort finished, held while start_i is high |

## Verification
The assertions assume that the host holds start_i high until it sees done_o, and that it lowers start_i afterwards. They also assume that mode_i and the host strobes change only between clock edges. The bench drives every input on the falling edge and keeps each sort request raised through the whole sort and a few cycles past done_o. Strobes sent in the middle of a sort are deliberate, so that R8 is exercised within those assumptions.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LDA,
    ST_LDB,
    ST_CMP,
    ST_WRI,
    ST_WRJ,
    ST_RLA,
    ST_DONE
  } sort_state_e;
endpackage

// File: rtl/sort_regfile.sv
module sort_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int K = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [K];

  for (genvar g = 0; g < K; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '0;
      else if (we_i && (waddr_i == ADDR_W'(g)))
        mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/sort_datapath.sv
module sort_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_a_i,
  input  logic              ld_b_i,
  input  logic              sel_b_i,
  input  logic [DATA_W-1:0] word_i_i,
  input  logic [DATA_W-1:0] word_j_i,
  output logic              b_lt_a_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [DATA_W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (ld_a_i) a_q <= word_i_i;
      if (ld_b_i) b_q <= word_j_i;
    end
  end

  // unsigned, strict: equal words stay put
  assign b_lt_a_o = b_q < a_q;
  assign wdata_o  = sel_b_i ? b_q : a_q;
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
  import sorter_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              start_i,
  input  logic              b_lt_a_i,
  output logic              ld_a_o,
  output logic              ld_b_o,
  output logic              wr_i_o,
  output logic              wr_j_o,
  output logic [ADDR_W-1:0] i_idx_o,
  output logic [ADDR_W-1:0] j_idx_o,
  output logic              idle_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int K = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_J = ADDR_W'(K - 1);
  localparam logic [ADDR_W-1:0] LAST_I = ADDR_W'(K - 2);

  sort_state_e st_q, st_d;
  logic [ADDR_W-1:0] i_q, i_d, j_q, j_d;

  always_comb begin
    st_d = st_q;
    i_d  = i_q;
    j_d  = j_q;
    unique case (st_q)
      ST_IDLE: if (mode_i && start_i) begin
        i_d  = '0;
        st_d = ST_LDA;
      end
      ST_LDA: begin
        j_d  = i_q + 1'b1;
        st_d = ST_LDB;
      end
      ST_LDB: st_d = ST_CMP;
      ST_WRI: st_d = ST_WRJ;
      ST_WRJ: st_d = ST_RLA;
      ST_CMP, ST_RLA: begin
        if (st_q == ST_CMP && b_lt_a_i) begin
          st_d = ST_WRI;
        end else if (j_q != LAST_J) begin
          j_d  = j_q + 1'b1;
          st_d = ST_LDB;
        end else if (i_q != LAST_I) begin
          i_d  = i_q + 1'b1;
          st_d = ST_LDA;
        end else begin
          st_d = ST_DONE;
        end
      end
      ST_DONE: if (!start_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      i_q  <= '0;
      j_q  <= '0;
    end else begin
      st_q <= st_d;
      i_q  <= i_d;
      j_q  <= j_d;
    end
  end

  assign ld_a_o  = (st_q == ST_LDA) || (st_q == ST_RLA);
  assign ld_b_o  = (st_q == ST_LDB);
  assign wr_i_o  = (st_q == ST_WRI);
  assign wr_j_o  = (st_q == ST_WRJ);
  assign i_idx_o = i_q;
  assign j_idx_o = j_q;
  assign idle_o  = (st_q == ST_IDLE);
  assign done_o  = (st_q == ST_DONE);
  assign busy_o  = !idle_o && !done_o;
endmodule

// File: rtl/reg_exchange_sorter.sv
module reg_exchange_sorter #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              start_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic              ld_a, ld_b, wr_i, wr_j, b_lt_a;
  logic              idle_w, busy_w, done_w;
  logic [ADDR_W-1:0] i_idx, j_idx, raddr_a, waddr;
  logic [DATA_W-1:0] word_i, word_j, dp_wdata, wdata;
  logic              host_wr, host_rd, rf_we;
  logic [DATA_W-1:0] data_q;

  assign host_wr = idle_w && !mode_i && wr_en_i;
  assign host_rd = idle_w && !mode_i && rd_en_i;
  assign rf_we   = host_wr || wr_i || wr_j;
  assign waddr   = wr_i ? i_idx : (wr_j ? j_idx : addr_i);
  assign wdata   = (wr_i || wr_j) ? dp_wdata : data_i;
  assign raddr_a = idle_w ? addr_i : i_idx;

  sort_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .start_i  (start_i),
    .b_lt_a_i (b_lt_a),
    .ld_a_o   (ld_a),
    .ld_b_o   (ld_b),
    .wr_i_o   (wr_i),
    .wr_j_o   (wr_j),
    .i_idx_o  (i_idx),
    .j_idx_o  (j_idx),
    .idle_o   (idle_w),
    .busy_o   (busy_w),
    .done_o   (done_w)
  );

  sort_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (raddr_a),
    .raddr_b_i (j_idx),
    .rdata_a_o (word_i),
    .rdata_b_o (word_j)
  );

  sort_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_a_i   (ld_a),
    .ld_b_i   (ld_b),
    .sel_b_i  (wr_i),
    .word_i_i (word_i),
    .word_j_i (word_j),
    .b_lt_a_o (b_lt_a),
    .wdata_o  (dp_wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (host_rd) data_q <= word_i;
  end

  assign data_o = data_q;
  assign done_o = done_w;
endmodule

// File: rtl/sorter_checker.sv
module sorter_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              start_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] data_o,
  input logic              done_o,
  input logic              idle,
  input logic              busy
);
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(data_o)); // R3

  AST_NO_START_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !mode_i) |=> idle); // R4

  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && mode_i && start_i) |=> busy); // R4

  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy)); // R6

  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (!done_o && idle)); // R7

  AST_DONE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> done_o); // R7

  AST_BUSY_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(data_o)); // R8
endmodule

bind reg_exchange_sorter sorter_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .start_i (start_i),
  .rd_en_i (rd_en_i),
  .data_o  (data_o),
  .done_o  (done_o),
  .idle    (idle_w),
  .busy    (busy_w)
);

// File: tb/sim_reg_exchange_sorter.sv
module sim_reg_exchange_sorter;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int K = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              mode_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0, start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              done_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  int model_mem [K];
  int last_read = 0;

  always #2.5 clk = ~clk;

  reg_exchange_sorter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .data_i(data_i), .start_i(start_i),
    .data_o(data_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input int v);
    @(negedge clk);
    mode_i = 1'b0; wr_en_i = 1'b1; addr_i = ADDR_W'(a); data_i = DATA_W'(v);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic host_read_check(input string req, input int a, input int exp);
    @(negedge clk);
    mode_i = 1'b0; rd_en_i = 1'b1; addr_i = ADDR_W'(a);
    @(negedge clk);
    rd_en_i = 1'b0;
    last_read = int'(data_o);
    check(req, int'(data_o), exp);
  endtask

  task automatic load4(input int v0, input int v1, input int v2, input int v3);
    model_mem[0] = v0; model_mem[1] = v1; model_mem[2] = v2; model_mem[3] = v3;
    for (int a = 0; a < K; a++) host_write(a, model_mem[a]);
  endtask

  // behavioural reference: sorts model_mem, returns edge count to done
  function automatic int model_sort();
    int t = 0;
    for (int i = 0; i < K - 1; i++) begin
      int a;
      t++;
      a = model_mem[i];
      for (int j = i + 1; j < K; j++) begin
        t += 2;
        if (model_mem[j] < a) begin
          model_mem[i] = model_mem[j];
          model_mem[j] = a;
          a = model_mem[i];
          t += 3;
        end
      end
    end
    return t;
  endfunction

  task automatic run_sort(input string req, input int exp_t, input bit poke);
    @(negedge clk);
    mode_i = 1'b1; start_i = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= exp_t; c++) begin
      @(negedge clk);
      if (poke && c == 3) begin
        mode_i = 1'b0; wr_en_i = 1'b1; rd_en_i = 1'b1; addr_i = '0; data_i = 8'hAA;
      end
      if (poke && c == 4) begin
        wr_en_i = 1'b0; rd_en_i = 1'b0; mode_i = 1'b1;
        check("R8 data_o held during sort", int'(data_o), last_read);
      end
      if (c == exp_t || c == exp_t - 1 || c == 0)
        check({req, " done timing"}, int'(done_o), (c == exp_t) ? 1 : 0);
      else if (done_o) check({req, " early done"}, 1, 0);
    end
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check("R7 done held", int'(done_o), 1);
    end
    start_i = 1'b0;
    @(negedge clk);
    check("R7 done released", int'(done_o), 0);
    mode_i = 1'b0;
  endtask

  task automatic check_sorted(input string req);
    for (int a = 0; a < K; a++) host_read_check(req, a, model_mem[a]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    check("R1 done after reset", int'(done_o), 0);
    check("R1 data_o after reset", int'(data_o), 0);
    rst_ni = 1'b1;
    for (int a = 0; a < K; a++) host_read_check("R1 word zero", a, 0);

    load4(3, 2, 4, 1);
    host_read_check("R2 R3 readback", 2, 4);
    host_read_check("R2 R3 readback", 3, 1);
    repeat (3) @(negedge clk);
    check("R3 data_o holds", int'(data_o), 1);

    // start with mode 0 must not run
    @(negedge clk);
    mode_i = 1'b0; start_i = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (done_o) check("R4 no sort in init mode", 1, 0);
    end
    check("R4 done stays low", int'(done_o), 0);
    start_i = 1'b0;
    host_read_check("R4 contents untouched", 0, 3);

    t = model_sort();
    check("R9 edge count", t, 27);
    run_sort("R9", 27, 1'b1);
    check_sorted("R9 R5 R8 result");

    load4(5, 5, 5, 5);
    t = model_sort();
    check("R6 equal words latency", t, 15);
    run_sort("R6", t, 1'b0);
    check_sorted("R6 equal words");

    load4(8'h80, 8'h7F, 8'hFF, 8'h00);
    t = model_sort();
    run_sort("R5 unsigned", t, 1'b0);
    check_sorted("R5 unsigned order");

    load4(4, 3, 2, 1);
    t = model_sort();
    run_sort("R6 reversed", t, 1'b0);
    check_sorted("R5 reversed input");

    load4(1, 2, 3, 4);
    t = model_sort();
    check("R6 sorted input latency", t, 15);
    run_sort("R6 sorted", t, 1'b0);
    check_sorted("R5 already sorted");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule